// File: doc/BRIEF.md
# Flash Access Protection Checker

This block stands between the bus-side command path of an on-chip flash and the controller of the flash array. Each request (a read, a page program or a page erase, aimed at main flash or at the option-byte area) is judged in one cycle. It is then passed on to the array as a grant pulse, answered on the bus with an error, or refused by raising a sticky protection-error flag. The decision draws on three things: a 32-bit active-low region mask, a 16-bit security word, and the debug and boot-mode inputs. All three arrive as stable registered values.

Main flash is split into 4 KB regions. Mask bits 0 to 30 guard one region each. Bit 31 guards everything from 124 KB upward. When the security word is not the open value, the lowest region can no longer be written. In debug or any non-user boot mode, main flash is then sealed completely. The block also raises a one-cycle mass-erase request when software writes the open value back into the option area while security is on. An option-area erase makes the mask read back as all ones until the next reset.

Top module: `flash_guard`

## Requirements
- R1: Bits 0 to 30 of `wp_mask` each guard one 4 KB region of main flash (bit i covers byte addresses i*4096 to i*4096+4095). Bit 31 guards every address from 0x1F000 upward. A bit value of 0 means protected.
- R2: A request that is allowed produces `grant` high for exactly the one cycle after the clock edge that samples `req_valid`. With no request, `grant` and `bus_err` stay low.
- R3: A refused program or erase sets `wp_err`, which stays high until a cycle with `err_clr` high. If a new refusal and `err_clr` fall in the same cycle, the flag ends up set.
- R4: When `sec_word` differs from 0x5AA5, a program or erase of region 0 is refused whatever `wp_mask` holds. Reads in user mode are still granted.
- R5: When `sec_word` differs from 0x5AA5 and any of `dbg_mode`, `boot_sram`, `boot_loader` is high, a main-flash read answers with `bus_err`, and a main-flash program or erase sets `wp_err`.
- R6: Requests with `req_opt` high (option-byte area) are never refused by the mask or by security. A granted option-area erase makes `wp_mask_rd` read all ones until reset. Otherwise `wp_mask_rd` equals `wp_mask`.
- R7: `irq` is the AND of `wp_err` and `irq_en`, delayed by one register stage.
- R8: An option-area program (`req_op` 1, `req_opt` 1) with `req_wdata` 0x5AA5 while `sec_word` differs from 0x5AA5 pulses `mass_erase_req` in the same cycle as its `grant`. In any other case `mass_erase_req` stays low.
- R9: `req_op` encodes 0 read, 1 page program, 2 page erase, 3 reserved. The reserved code is always answered with `bus_err`. Every request has exactly one outcome: grant, bus error, or flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (0 read, 1 program, 2 erase, 3 reserved) |
| req_opt | input | 1 | Request targets the option-byte area |
| req_addr | input | 20 | Byte address within main flash |
| req_wdata | input | 16 | Write data of a program request |
| wp_mask | input | 32 | Stored region mask, active low |
| sec_word | input | 16 | Security byte and complement as one word |
| dbg_mode | input | 1 | Debugger attached |
| boot_sram | input | 1 | Booted from SRAM |
| boot_loader | input | 1 | Booted from the boot loader |
| irq_en | input | 1 | Error interrupt enable |
| err_clr | input | 1 | Write-1-to-clear strobe for the error flag |
| grant | output | 1 | One-cycle pass-on pulse to the array controller |
| bus_err | output | 1 | One-cycle bus error response |
| wp_err | output | 1 | Sticky protection-error flag |
| irq | output | 1 | Flash operation error interrupt |
| mass_erase_req | output | 1 | One-cycle request to mass-erase main flash |
| wp_mask_rd | output | 32 | Effective region mask as read back |

## Verification
The hardest state to reach is the one after an option-area erase. In it the stored mask still reports protected regions, but the effective mask must read all ones, and a write to a formerly protected region must now be granted. The bench first confirms that the write is refused. It then issues the option erase, repeats the write, and finally resets to show that the override is gone. The region boundaries at 0x1EFFF and 0x1F000 are also visited with masks that differ only in bits 30 and 31. This separates a catch-all region that starts one region too early or too late.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam logic [15:0] SEC_OPEN = 16'h5AA5;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } fg_op_e;

    typedef enum logic [1:0] {
        OUT_GRANT  = 2'd0,
        OUT_BUSERR = 2'd1,
        OUT_WPERR  = 2'd2
    } fg_outcome_e;

    typedef struct packed {
        fg_outcome_e outcome;
        logic        mass_erase;
        logic        opt_erase;
    } fg_verdict_t;

    function automatic logic sec_locked(input logic [15:0] word);
        return word != SEC_OPEN;
    endfunction

    function automatic logic is_write(input fg_op_e op);
        return (op == OP_PROG) || (op == OP_ERASE);
    endfunction

endpackage

// File: rtl/fg_region_decode.sv
module fg_region_decode #(
    parameter int ADDR_W       = 20,
    parameter int REGION_SHIFT = 12,
    parameter int NUM_REGIONS  = 32
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NUM_REGIONS-1:0] mask,
    output logic                   region_prot,
    output logic                   region_first
);
    localparam int IDX_W = ADDR_W - REGION_SHIFT;
    localparam int LAST  = NUM_REGIONS - 1;

    logic [IDX_W-1:0]       page;
    logic [NUM_REGIONS-1:0] hit;

    assign page = addr[ADDR_W-1:REGION_SHIFT];

    // uniform regions, one per mask bit
    generate
        for (genvar i = 0; i < LAST; i++) begin : g_region
            assign hit[i] = (page == IDX_W'(i));
        end
    endgenerate

    // catch-all region covers the rest of main flash
    assign hit[LAST] = (page >= IDX_W'(LAST));

    assign region_prot  = |(hit & ~mask);
    assign region_first = hit[0];

endmodule

// File: rtl/fg_policy.sv
module fg_policy
    import flash_guard_pkg::*;
(
    input  fg_op_e      op,
    input  logic        opt,
    input  logic        region_prot,
    input  logic        region_first,
    input  logic [15:0] sec_word,
    input  logic        dbg_mode,
    input  logic        boot_sram,
    input  logic        boot_loader,
    input  logic [15:0] wdata,
    output fg_verdict_t verdict
);
    logic sec_on;
    logic sealed;

    assign sec_on = sec_locked(sec_word);
    assign sealed = sec_on && (dbg_mode || boot_sram || boot_loader);

    always_comb begin
        verdict = '{outcome: OUT_GRANT, mass_erase: 1'b0, opt_erase: 1'b0};
        if (op == OP_RSVD) begin
            verdict.outcome = OUT_BUSERR;
        end else if (opt) begin
            verdict.opt_erase  = (op == OP_ERASE);
            verdict.mass_erase = (op == OP_PROG) && (wdata == SEC_OPEN) && sec_on;
        end else if (op == OP_READ) begin
            if (sealed) verdict.outcome = OUT_BUSERR;
        end else if (is_write(op)) begin
            if (sealed || region_prot || (sec_on && region_first))
                verdict.outcome = OUT_WPERR;
        end
    end

endmodule

// File: rtl/fg_err_ctrl.sv
module fg_err_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_w1,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (set_evt)     flag <= 1'b1;
            else if (clr_w1) flag <= 1'b0;
            irq <= flag & irq_en;
        end
    end

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(flag) && !$past(clr_w1)) |-> flag);

    // R3
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(set_evt) |-> flag);

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        irq == $past(flag && irq_en));

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int REGION_SHIFT = 12,
    parameter int NUM_REGIONS  = 32,
    parameter int SEC_W        = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic                   req_opt,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [SEC_W-1:0]       req_wdata,
    input  logic [NUM_REGIONS-1:0] wp_mask,
    input  logic [SEC_W-1:0]       sec_word,
    input  logic                   dbg_mode,
    input  logic                   boot_sram,
    input  logic                   boot_loader,
    input  logic                   irq_en,
    input  logic                   err_clr,
    output logic                   grant,
    output logic                   bus_err,
    output logic                   wp_err,
    output logic                   irq,
    output logic                   mass_erase_req,
    output logic [NUM_REGIONS-1:0] wp_mask_rd
);
    logic        opt_wiped_q;
    logic        region_prot;
    logic        region_first;
    fg_verdict_t verdict;
    fg_op_e      op;

    assign op         = fg_op_e'(req_op);
    assign wp_mask_rd = wp_mask | {NUM_REGIONS{opt_wiped_q}};

    fg_region_decode #(
        .ADDR_W      (ADDR_W),
        .REGION_SHIFT(REGION_SHIFT),
        .NUM_REGIONS (NUM_REGIONS)
    ) u_decode (
        .addr        (req_addr),
        .mask        (wp_mask_rd),
        .region_prot (region_prot),
        .region_first(region_first)
    );

    fg_policy u_policy (
        .op          (op),
        .opt         (req_opt),
        .region_prot (region_prot),
        .region_first(region_first),
        .sec_word    (sec_word),
        .dbg_mode    (dbg_mode),
        .boot_sram   (boot_sram),
        .boot_loader (boot_loader),
        .wdata       (req_wdata),
        .verdict     (verdict)
    );

    fg_err_ctrl u_err (
        .clk    (clk),
        .rst    (rst),
        .set_evt(req_valid && verdict.outcome == OUT_WPERR),
        .clr_w1 (err_clr),
        .irq_en (irq_en),
        .flag   (wp_err),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant          <= 1'b0;
            bus_err        <= 1'b0;
            mass_erase_req <= 1'b0;
            opt_wiped_q    <= 1'b0;
        end else begin
            grant          <= req_valid && verdict.outcome == OUT_GRANT;
            bus_err        <= req_valid && verdict.outcome == OUT_BUSERR;
            mass_erase_req <= req_valid && verdict.outcome == OUT_GRANT && verdict.mass_erase;
            if (req_valid && verdict.outcome == OUT_GRANT && verdict.opt_erase)
                opt_wiped_q <= 1'b1;
        end
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(req_valid) |-> !(grant || bus_err || mass_erase_req));

    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid) |-> ($countones({grant, bus_err}) == 1 || wp_err));

    // R9
    grant_berr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant && bus_err));

    // R6
    opt_never_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_opt && req_op != 2'd3) |-> grant);

    // R5
    sealed_read_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && !req_opt && req_op == 2'd0 && sec_word != 16'h5AA5
              && (dbg_mode || boot_sram || boot_loader)) |-> bus_err);

    // R8
    mass_with_grant_chk: assert property (@(posedge clk) disable iff (rst)
        mass_erase_req |-> grant);

endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_opt = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [31:0] wp_mask = 32'hFFFF_FFFF;
    logic [15:0] sec_word = 16'h5AA5;
    logic        dbg_mode = 1'b0, boot_sram = 1'b0, boot_loader = 1'b0;
    logic        irq_en = 1'b0, err_clr = 1'b0;
    logic        grant, bus_err, wp_err, irq, mass_erase_req;
    logic [31:0] wp_mask_rd;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    flash_guard u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_opt(req_opt), .req_addr(req_addr), .req_wdata(req_wdata),
        .wp_mask(wp_mask), .sec_word(sec_word), .dbg_mode(dbg_mode),
        .boot_sram(boot_sram), .boot_loader(boot_loader), .irq_en(irq_en),
        .err_clr(err_clr), .grant(grant), .bus_err(bus_err), .wp_err(wp_err),
        .irq(irq), .mass_erase_req(mass_erase_req), .wp_mask_rd(wp_mask_rd)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic        opt;
        logic [19:0] addr;
        logic [15:0] sec;
        logic [2:0]  mode;   // {dbg, sram, loader}
        logic [31:0] mask;
        logic [2:0]  exp;    // {grant, bus_err, wp_err}
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 20'h00000, 16'h5AA5, 3'b000, 32'hFFFF_FFFF, 3'b100}, // R2
        '{2'd1, 1'b0, 20'h03000, 16'h5AA5, 3'b000, 32'hFFFF_FFF7, 3'b001}, // R1
        '{2'd2, 1'b0, 20'h04000, 16'h5AA5, 3'b000, 32'hFFFF_FFF7, 3'b100}, // R1
        '{2'd1, 1'b0, 20'h1EFFF, 16'h5AA5, 3'b000, 32'hBFFF_FFFF, 3'b001}, // R1
        '{2'd1, 1'b0, 20'h1F000, 16'h5AA5, 3'b000, 32'hBFFF_FFFF, 3'b100}, // R1
        '{2'd1, 1'b0, 20'h1F000, 16'h5AA5, 3'b000, 32'h7FFF_FFFF, 3'b001}, // R1
        '{2'd2, 1'b0, 20'hFF000, 16'h5AA5, 3'b000, 32'h7FFF_FFFF, 3'b001}, // R1
        '{2'd1, 1'b0, 20'h1EFFF, 16'h5AA5, 3'b000, 32'h7FFF_FFFF, 3'b100}, // R1
        '{2'd2, 1'b0, 20'h00800, 16'h0000, 3'b000, 32'hFFFF_FFFF, 3'b001}, // R4
        '{2'd1, 1'b0, 20'h01000, 16'h0000, 3'b000, 32'hFFFF_FFFF, 3'b100}, // R4
        '{2'd0, 1'b0, 20'h00000, 16'h0000, 3'b000, 32'hFFFF_FFFF, 3'b100}, // R4
        '{2'd0, 1'b0, 20'h22000, 16'hFFFF, 3'b100, 32'hFFFF_FFFF, 3'b010}, // R5
        '{2'd0, 1'b0, 20'h05000, 16'h1234, 3'b010, 32'hFFFF_FFFF, 3'b010}, // R5
        '{2'd1, 1'b0, 20'h05000, 16'hA55A, 3'b001, 32'hFFFF_FFFF, 3'b001}, // R5
        '{2'd0, 1'b0, 20'h05000, 16'h5AA5, 3'b111, 32'hFFFF_FFFF, 3'b100}, // R5
        '{2'd0, 1'b1, 20'h00000, 16'h0000, 3'b100, 32'h0000_0000, 3'b100}, // R6
        '{2'd1, 1'b1, 20'h00000, 16'h0000, 3'b111, 32'h0000_0000, 3'b100}, // R6
        '{2'd3, 1'b0, 20'h05000, 16'h5AA5, 3'b000, 32'hFFFF_FFFF, 3'b010}  // R9
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // drive one request for one cycle; returns at the negedge after the sampling edge
    task automatic issue(input logic [1:0] op, input logic opt,
                         input logic [19:0] addr, input logic [15:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_opt = opt; req_addr = addr; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R2 R3 R7 R8 R6: reset state
        chk("R2 reset grant", {31'd0, grant}, 32'd0);
        chk("R9 reset bus_err", {31'd0, bus_err}, 32'd0);
        chk("R3 reset wp_err", {31'd0, wp_err}, 32'd0);
        chk("R7 reset irq", {31'd0, irq}, 32'd0);
        chk("R8 reset mass", {31'd0, mass_erase_req}, 32'd0);
        chk("R6 reset mask read", wp_mask_rd, 32'hFFFF_FFFF);

        for (int i = 0; i < NV; i++) begin
            wp_mask  = VECS[i].mask;
            sec_word = VECS[i].sec;
            {dbg_mode, boot_sram, boot_loader} = VECS[i].mode;
            issue(VECS[i].op, VECS[i].opt, VECS[i].addr, 16'h0000);
            chk($sformatf("R9 vector %0d outcome", i), {29'd0, grant, bus_err, wp_err},
                {29'd0, VECS[i].exp});
            @(negedge clk);
            chk($sformatf("R2 vector %0d pulse ends", i), {30'd0, grant, bus_err}, 32'd0);
            clear_flag();
        end
        {dbg_mode, boot_sram, boot_loader} = 3'b000;

        // R3 R7: sticky flag, irq one stage later, write-1-to-clear
        irq_en = 1'b1; sec_word = 16'h5AA5; wp_mask = 32'hFFFF_FFFE;
        issue(2'd1, 1'b0, 20'h00010, 16'h0000);
        chk("R3 flag set", {31'd0, wp_err}, 32'd1);
        chk("R7 irq not yet", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R7 irq asserted", {31'd0, irq}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R3 flag holds", {31'd0, wp_err}, 32'd1);
        irq_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R7 irq masked", {31'd0, irq}, 32'd0);
        clear_flag();
        chk("R3 flag cleared", {31'd0, wp_err}, 32'd0);

        // R3: refusal and clear in the same cycle leave the flag set
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd2; req_opt = 1'b0; req_addr = 20'h00000; err_clr = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; err_clr = 1'b0;
        chk("R3 set wins over clear", {31'd0, wp_err}, 32'd1);
        clear_flag();

        // R8: mass-erase request only when security is lowered
        sec_word = 16'h0000;
        issue(2'd1, 1'b1, 20'h00000, 16'h5AA5);
        chk("R8 mass erase raised", {30'd0, mass_erase_req, grant}, 32'd3);
        @(negedge clk);
        chk("R8 mass erase one cycle", {31'd0, mass_erase_req}, 32'd0);
        issue(2'd1, 1'b1, 20'h00000, 16'h1234);
        chk("R8 other data no mass", {30'd0, mass_erase_req, grant}, 32'd1);
        sec_word = 16'h5AA5;
        issue(2'd1, 1'b1, 20'h00000, 16'h5AA5);
        chk("R8 open security no mass", {30'd0, mass_erase_req, grant}, 32'd1);

        // R6: option erase lifts all region protection until reset
        wp_mask = 32'h7FFF_FFF0;
        issue(2'd1, 1'b0, 20'h02000, 16'h0000);
        chk("R6 protected before option erase", {29'd0, grant, bus_err, wp_err}, 32'd1);
        clear_flag();
        issue(2'd2, 1'b1, 20'h00000, 16'h0000);
        chk("R6 option erase granted", {31'd0, grant}, 32'd1);
        chk("R6 mask reads all ones", wp_mask_rd, 32'hFFFF_FFFF);
        issue(2'd1, 1'b0, 20'h02000, 16'h0000);
        chk("R6 write now granted", {29'd0, grant, bus_err, wp_err}, 32'd4);
        issue(2'd1, 1'b0, 20'h40000, 16'h0000);
        chk("R6 catch-all now granted", {29'd0, grant, bus_err, wp_err}, 32'd4);
        do_reset();
        @(negedge clk);
        chk("R6 reset restores mask", wp_mask_rd, 32'h7FFF_FFF0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule